// File: doc/BRIEF.md
# EDO DRAM access controller

This block sits between a synchronous host and a 64K x 16 asynchronous EDO DRAM that has a multiplexed address bus. The host offers one word request at a time through a request/ready handshake. Each request carries a 16-bit word address, a read/write flag, two byte enables and write data. The controller turns each request into a row-strobe/column-strobe sequence on the DRAM pins and returns read data with a one-cycle valid pulse.

Rows are left open after an access. A following request to the same row is served as a page-mode column cycle with RAS held low. A request to a different row closes the open row, waits out the precharge, and opens the new one. Every write is an early write: the byte write strobes fall before the column strobe, so the DRAM keeps its outputs in high impedance for the whole cycle.

A separate refresh block asks for the DRAM through `ref_req`. The controller closes any open row, honours precharge, and then raises `ref_gnt`. While the grant is held it keeps every strobe inactive. All timing limits are parameters counted in system clock cycles. The defaults are rounded up from the nanosecond limits for a 100 MHz clock.

Top module: `edoram_ctrl`

## Requirements
- R1: The row is `host_addr[15:8]`, presented on `dram_addr` when `dram_ras_n` falls. The column is `host_addr[7:0]`, presented on `dram_addr` when `dram_cas_n` falls.
- R2: At the column-strobe fall of a write, `dram_wrhi_n` is low exactly when `host_be[1]` is set and `dram_wrlo_n` is low exactly when `host_be[0]` is set. `dram_dq_oe` is high and `dram_dq_out` carries the write data. No strobe falls while `dram_cas_n` is low. With `host_be` = 00 the stored word is left unchanged.
- R3: For a read, `dram_oe_n` is low while `dram_cas_n` is low. The data bus is sampled no earlier than `T_CAC` cycles after the column strobe falls. The sampled word appears on `host_rdata` with `host_rvalid` high for exactly one cycle, in request order.
- R4: `dram_ras_n` stays low for at least `T_RAS` cycles and high for at least `T_RP` cycles. Successive falls of `dram_ras_n` are at least `T_RC` cycles apart.
- R5: `dram_cas_n` falls only while `dram_ras_n` is low, at least `T_RCD` cycles after the RAS fall. It stays low for at least `T_CAS` cycles and stays high for at least one cycle between page accesses.
- R6: A request whose row equals the open row is served without a new fall of `dram_ras_n`.
- R7: A request to another row raises `dram_ras_n`, precharges, and reopens, giving exactly one new RAS fall.
- R8: `dram_ras_n` never stays low for more than `T_RASP` cycles, even under a continuous stream of same-row requests.
- R9: `dram_dq_oe` is high only during writes and `dram_oe_n` is low only during reads. The two are never active together.
- R10: While `ref_req` is high, `host_rdy` is low. `ref_gnt` rises only after the row is closed and precharged. While granted, all strobes are high and the data bus is released. After the grant ends, the next access opens its row afresh.
- R11: After reset the strobes and output enable are high, `dram_dq_oe`, `ref_gnt` and `host_rvalid` are low, and `host_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request valid |
| host_rdy | output | 1 | Controller accepts the request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address, row in the upper byte |
| host_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | One-cycle pulse, read data valid |
| ref_req | input | 1 | Refresh block wants the DRAM |
| ref_gnt | output | 1 | DRAM handed to the refresh block |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_n | output | 1 | Column address strobe, active low |
| dram_wrhi_n | output | 1 | Upper byte write strobe, active low |
| dram_wrlo_n | output | 1 | Lower byte write strobe, active low |
| dram_oe_n | output | 1 | DRAM output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_in | input | 16 | Data read from the DRAM |

## Verification
The bench's DRAM model returns garbage until the column strobe has been low for `T_CAC` cycles. A controller that samples too early therefore hands back a wrong word. Byte-lane writes, including a write with no lane enabled, are read back through the host port. A swapped or missing strobe then shows up as a corrupted byte. RAS falls are counted across same-row bursts, row changes and refresh grants. A design that reopens on every hit, keeps a stale row after refresh, or lets a long same-row stream hold RAS beyond `T_RASP` shows a wrong count or a measured pulse that is too long.

// File: rtl/edoram_pkg.sv
package edoram_pkg;

  localparam int DQ_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_PAGE,
    ST_CLOSE
  } st_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edoram_tmr.sv
module edoram_tmr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)
      cnt_d = ld_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/edoram_age.sv
module edoram_age #(
  parameter int W    = 8,
  parameter int MAXV = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = W'(1);
    else if (run && (cnt_q != W'(MAXV)))
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/edoram_ctrl.sv
module edoram_ctrl #(
  parameter int AW     = 16,
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 7,
  parameter int T_RP   = 5,
  parameter int T_RC   = 13,
  parameter int T_CAS  = 2,
  parameter int T_CAC  = 3,
  parameter int T_RASP = 10000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           host_req,
  output logic                           host_rdy,
  input  logic                           host_we,
  input  logic [AW-1:0]                  host_addr,
  input  logic [1:0]                     host_be,
  input  logic [edoram_pkg::DQ_W-1:0]    host_wdata,
  output logic [edoram_pkg::DQ_W-1:0]    host_rdata,
  output logic                           host_rvalid,
  input  logic                           ref_req,
  output logic                           ref_gnt,
  output logic [AW/2-1:0]                dram_addr,
  output logic                           dram_ras_n,
  output logic                           dram_cas_n,
  output logic                           dram_wrhi_n,
  output logic                           dram_wrlo_n,
  output logic                           dram_oe_n,
  output logic [edoram_pkg::DQ_W-1:0]    dram_dq_out,
  output logic                           dram_dq_oe,
  input  logic [edoram_pkg::DQ_W-1:0]    dram_dq_in
);
  import edoram_pkg::*;

  localparam int RW   = AW / 2;
  localparam int CASR = imax(T_CAS, T_CAC);
  localparam int TMAX = imax(imax(T_RC, T_RP), imax(CASR, T_RCD));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int AGW  = $clog2(T_RASP + 1);
  localparam int LIM  = T_RASP - CASR - 4;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  st_t             st_q, st_d;
  logic            pend_q, pend_d;
  logic [RW-1:0]   row_q, row_d;
  logic            we_q;
  logic [1:0]      be_q;
  logic [AW-1:0]   addr_q;
  logic [DQ_W-1:0] wdata_q;

  logic            tmr_ld, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            pre_ld, pre_zero;
  logic [TW-1:0]   pre_val;
  logic            age_start;
  logic [AGW-1:0]  age;
  logic            cap;

  logic            accept, lim, hit, close_ok;

  // step timer for RAS-to-CAS and CAS pulse
  edoram_tmr #(.W(TW)) step_tmr_i (
    .clk(clk), .rst_n(rst_q), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
  );

  // precharge timer, runs while the row is closed
  edoram_tmr #(.W(TW)) pre_tmr_i (
    .clk(clk), .rst_n(rst_q), .ld(pre_ld), .ld_val(pre_val), .zero(pre_zero)
  );

  // age of the open row in cycles
  edoram_age #(.W(AGW), .MAXV(T_RASP)) row_age_i (
    .clk(clk), .rst_n(rst_q), .start(age_start), .run(!dram_ras_n), .cnt(age)
  );

  assign lim      = (age >= AGW'(LIM));
  assign close_ok = (age >= AGW'(T_RAS));
  assign hit      = (addr_q[AW-1:RW] == row_q);
  assign host_rdy = !pend_q && !ref_req &&
                    ((st_q == ST_IDLE) || ((st_q == ST_PAGE) && !lim));
  assign accept   = host_req && host_rdy;

  // next state
  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q || accept;
    row_d     = row_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    pre_ld    = 1'b0;
    pre_val   = '0;
    age_start = 1'b0;
    cap       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pre_zero) begin
          if (ref_req) begin
            st_d = ST_REF;
          end else if (pend_q) begin
            st_d      = ST_RCD;
            tmr_ld    = 1'b1;
            tmr_val   = TW'(T_RCD - 1);
            age_start = 1'b1;
            row_d     = addr_q[AW-1:RW];
          end
        end
      end
      ST_REF: begin
        if (!ref_req) begin
          st_d    = ST_IDLE;
          pre_ld  = 1'b1;
          pre_val = TW'(T_RP - 1);
        end
      end
      ST_RCD: begin
        if (tmr_zero) st_d = ST_COL;
      end
      ST_COL: begin
        st_d    = ST_CAS;
        tmr_ld  = 1'b1;
        tmr_val = we_q ? TW'(T_CAS - 1) : TW'(CASR - 1);
      end
      ST_CAS: begin
        if (tmr_zero) begin
          st_d   = ST_PAGE;
          pend_d = 1'b0;
          cap    = !we_q;
        end
      end
      ST_PAGE: begin
        if (ref_req || lim)
          st_d = ST_CLOSE;
        else if (pend_q)
          st_d = hit ? ST_COL : ST_CLOSE;
      end
      ST_CLOSE: begin
        if (close_ok) begin
          st_d   = ST_IDLE;
          pre_ld = 1'b1;
          if (int'(age) + T_RP < T_RC)
            pre_val = TW'(T_RC - int'(age) - 1);
          else
            pre_val = TW'(T_RP - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // pin values derived from the next state
  logic            wr_d;
  logic            ras_n_d, cas_n_d, oe_n_d, gnt_d;
  logic [RW-1:0]   addr_pin_d;
  assign wr_d       = ((st_d == ST_COL) || (st_d == ST_CAS)) && we_q;
  assign ras_n_d    = (st_d == ST_IDLE) || (st_d == ST_REF);
  assign cas_n_d    = (st_d != ST_CAS);
  assign oe_n_d     = !((st_d == ST_CAS) && !we_q);
  assign gnt_d      = (st_d == ST_REF);
  assign addr_pin_d = (st_d == ST_RCD) ? addr_q[AW-1:RW] : addr_q[RW-1:0];

  // control registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q        <= ST_IDLE;
      pend_q      <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_wrhi_n <= 1'b1;
      dram_wrlo_n <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      ref_gnt     <= 1'b0;
      host_rvalid <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_q      <= pend_d;
      dram_ras_n  <= ras_n_d;
      dram_cas_n  <= cas_n_d;
      dram_wrhi_n <= !(wr_d && be_q[1]);
      dram_wrlo_n <= !(wr_d && be_q[0]);
      dram_oe_n   <= oe_n_d;
      dram_dq_oe  <= wr_d;
      ref_gnt     <= gnt_d;
      host_rvalid <= cap;
    end
  end

  // data registers, no reset, written under explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      we_q    <= host_we;
      be_q    <= host_be;
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
    if (st_d != st_q)
      row_q <= row_d;
    dram_addr   <= addr_pin_d;
    dram_dq_out <= wdata_q;
    if (cap)
      host_rdata <= dram_dq_in;
  end
endmodule

// File: rtl/edoram_chk.sv
module edoram_chk #(
  parameter int T_RAS  = 7,
  parameter int T_RP   = 5,
  parameter int T_RASP = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic wrhi_n,
  input logic wrlo_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ref_req,
  input logic ref_gnt,
  input logic host_rdy,
  input logic host_rvalid
);
  localparam int CW = $clog2(T_RASP + 2);

  logic [CW-1:0] lo_cnt;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= CW'(T_RP);
    end else begin
      if (ras_n) lo_cnt <= '0;
      else if (lo_cnt != CW'(T_RASP + 1)) lo_cnt <= lo_cnt + CW'(1);
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt != CW'(T_RP)) hi_cnt <= hi_cnt + CW'(1);
    end
  end

  p_ras_low_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= CW'(T_RAS)));

  p_ras_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= CW'(T_RP)));

  p_ras_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (lo_cnt < CW'(T_RASP)));

  p_cas_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  p_strobe_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wrhi_n) || $fell(wrlo_n)) |-> cas_n);

  p_bus_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  p_gnt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && cas_n && wrhi_n && wrlo_n && !dq_oe));

  p_rdy_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !host_rdy);

  p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
endmodule

bind edoram_ctrl edoram_chk #(.T_RAS(T_RAS), .T_RP(T_RP), .T_RASP(T_RASP)) chk_i (
  .clk(clk), .rst_n(rst_q), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .wrhi_n(dram_wrhi_n), .wrlo_n(dram_wrlo_n), .oe_n(dram_oe_n),
  .dq_oe(dram_dq_oe), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .host_rdy(host_rdy), .host_rvalid(host_rvalid)
);

// File: tb/edoram_ctrl_tb_top.sv
module edoram_ctrl_tb_top;
  localparam int T_RCD = 2, T_RAS = 7, T_RP = 5, T_RC = 13, T_CAS = 2, T_CAC = 3;
  localparam int T_RASP = 400;

  logic clk = 1'b0;
  logic rst_n;
  logic host_req, host_rdy, host_we, host_rvalid;
  logic [15:0] host_addr, host_wdata, host_rdata;
  logic [1:0] host_be;
  logic ref_req, ref_gnt;
  logic [7:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_wrhi_n, dram_wrlo_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  always #4 clk = ~clk;

  edoram_ctrl #(.T_RASP(T_RASP)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rdy(host_rdy),
    .host_we(host_we), .host_addr(host_addr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_wrhi_n(dram_wrhi_n),
    .dram_wrlo_n(dram_wrlo_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard state
  typedef struct packed { logic we; logic [1:0] be; logic [15:0] addr; logic [15:0] wd; } acc_t;
  acc_t        accq[$];
  logic [15:0] rexp[$];
  logic [15:0] refm[int];
  logic [15:0] dmem[int];

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 16'h0000;
  endfunction

  task automatic do_req(input logic we, input logic [15:0] a, input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] cur;
    acc_t e;
    e.we = we; e.be = be; e.addr = a; e.wd = wd;
    accq.push_back(e);
    cur = ref_rd(a);
    if (we) begin
      if (be[1]) cur[15:8] = wd[15:8];
      if (be[0]) cur[7:0]  = wd[7:0];
      refm[int'(a)] = cur;
    end else begin
      rexp.push_back(cur);
    end
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    #1;
    while (!host_rdy) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      if (accq.size() == 0 && rexp.size() == 0) break;
      @(negedge clk);
    end
    repeat (30) @(negedge clk);
  endtask

  // DRAM model and pin-timing monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_wh = 1'b1, prev_wl = 1'b1;
  int ras_lo = 0, ras_hi = 0, since_fall = 0, cas_lo = 0, cas_hi = 0, ras_falls = 0;
  bit seen_rise = 0, first_cas = 0;
  logic [7:0] row_l, col_l;
  logic [15:0] rd_word = 16'h0;

  always_comb dram_dq_in = (!dram_cas_n && !dram_oe_n && cas_lo >= T_CAC) ? rd_word : 16'hBAD0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_ras_n && prev_ras) begin
        ras_falls++;
        if (seen_rise) begin
          chk(ras_hi >= T_RP, "R4 precharge width", ras_hi, T_RP);
          chk(since_fall + 1 >= T_RC, "R4 row cycle", since_fall + 1, T_RC);
        end
        row_l = dram_addr; since_fall = 1; ras_lo = 1; first_cas = 1;
      end else if (!dram_ras_n) begin
        ras_lo++; since_fall++;
      end else if (!prev_ras) begin
        chk(ras_lo >= T_RAS, "R4 RAS low width", ras_lo, T_RAS);
        chk(ras_lo <= T_RASP, "R8 RAS low max", ras_lo, T_RASP);
        ras_hi = 1; since_fall++; seen_rise = 1;
      end else begin
        ras_hi++; since_fall++;
      end

      if (!dram_cas_n && prev_cas) begin
        acc_t e;
        cas_lo = 1; col_l = dram_addr;
        chk(!dram_ras_n, "R5 CAS inside RAS", dram_ras_n, 0);
        if (first_cas) chk(since_fall - 1 >= T_RCD, "R5 RAS to CAS", since_fall - 1, T_RCD);
        else chk(cas_hi >= 1, "R5 CAS precharge", cas_hi, 1);
        first_cas = 0;
        chk(!(dram_dq_oe && !dram_oe_n), "R9 bus exclusive", {dram_dq_oe, dram_oe_n}, 2'b11);
        if (accq.size() == 0) begin
          chk(0, "R1 unexpected column cycle", col_l, 0);
        end else begin
          e = accq.pop_front();
          chk(row_l == e.addr[15:8], "R1 row address", row_l, e.addr[15:8]);
          chk(col_l == e.addr[7:0], "R1 column address", col_l, e.addr[7:0]);
          if (e.we) begin
            logic [15:0] w;
            chk({dram_wrhi_n, dram_wrlo_n} == ~e.be, "R2 byte strobes", {dram_wrhi_n, dram_wrlo_n}, ~e.be);
            chk(dram_dq_oe && dram_dq_out == e.wd, "R2 write data", dram_dq_out, e.wd);
            chk(dram_oe_n, "R9 oe during write", dram_oe_n, 1);
            w = dmem.exists(int'({row_l, col_l})) ? dmem[int'({row_l, col_l})] : 16'h0;
            if (!dram_wrhi_n) w[15:8] = dram_dq_out[15:8];
            if (!dram_wrlo_n) w[7:0]  = dram_dq_out[7:0];
            dmem[int'({row_l, col_l})] = w;
          end else begin
            chk(!dram_oe_n && !dram_dq_oe && dram_wrhi_n && dram_wrlo_n, "R3 read pins",
                {dram_oe_n, dram_dq_oe, dram_wrhi_n, dram_wrlo_n}, 4'b0011);
          end
        end
        rd_word = dmem.exists(int'({row_l, col_l})) ? dmem[int'({row_l, col_l})] : 16'h0;
      end else if (!dram_cas_n) begin
        cas_lo++;
        if ((!dram_wrhi_n && prev_wh) || (!dram_wrlo_n && prev_wl))
          chk(0, "R2 late write strobe", 1, 0);
      end else if (!prev_cas) begin
        chk(cas_lo >= T_CAS, "R5 CAS low width", cas_lo, T_CAS);
        cas_lo = 0; cas_hi = 1;
      end else begin
        cas_hi++;
      end

      if (ref_gnt && (!dram_ras_n || !dram_cas_n || dram_dq_oe))
        chk(0, "R10 pins active during grant", {dram_ras_n, dram_cas_n, dram_dq_oe}, 3'b110);

      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
      prev_wh = dram_wrhi_n; prev_wl = dram_wrlo_n;
    end
  end

  // read-data monitor
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (rexp.size() == 0) chk(0, "R3 unexpected read data", host_rdata, 0);
      else begin
        logic [15:0] x;
        x = rexp.pop_front();
        chk(host_rdata == x, "R3 read data", host_rdata, x);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    logic [15:0] lf;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_be = '0; host_wdata = '0; ref_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(dram_ras_n && dram_cas_n && dram_wrhi_n && dram_wrlo_n && dram_oe_n, "R11 strobes idle",
        {dram_ras_n, dram_cas_n, dram_wrhi_n, dram_wrlo_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !ref_gnt && !host_rvalid, "R11 enables low",
        {dram_dq_oe, ref_gnt, host_rvalid}, 0);
    chk(host_rdy, "R11 ready after reset", host_rdy, 1);

    // R2 R3 full word write and read
    do_req(1, 16'h1234, 2'b11, 16'hA5C3);
    do_req(0, 16'h1234, 2'b00, 16'h0);
    // R2 byte lanes, including no lane enabled
    do_req(1, 16'h1240, 2'b11, 16'hFFFF);
    do_req(1, 16'h1240, 2'b10, 16'h1299);
    do_req(1, 16'h1240, 2'b01, 16'h7734);
    do_req(1, 16'h1240, 2'b00, 16'h0000);
    do_req(0, 16'h1240, 2'b00, 16'h0);
    drain();

    // R6 page hits keep RAS low
    f0 = ras_falls;
    do_req(0, 16'h1234, 2'b00, 16'h0);
    do_req(1, 16'h12FF, 2'b11, 16'h0F0F);
    do_req(0, 16'h12FF, 2'b00, 16'h0);
    do_req(0, 16'h1200, 2'b00, 16'h0);
    drain();
    chk(ras_falls == f0, "R6 no RAS fall on page hit", ras_falls - f0, 0);

    // R7 row miss reopens once per change
    f0 = ras_falls;
    do_req(1, 16'h5678, 2'b11, 16'hBEEF);
    do_req(0, 16'h1234, 2'b00, 16'h0);
    do_req(0, 16'h5678, 2'b00, 16'h0);
    drain();
    chk(ras_falls == f0 + 3, "R7 one RAS fall per row change", ras_falls - f0, 3);

    // R10 refresh while a row is open
    @(negedge clk);
    ref_req = 1'b1;
    #1;
    chk(!host_rdy, "R10 ready low under refresh request", host_rdy, 0);
    for (int i = 0; i < 60; i++) begin
      if (ref_gnt) break;
      @(negedge clk);
    end
    chk(ref_gnt, "R10 grant given", ref_gnt, 1);
    chk(dram_ras_n && dram_cas_n, "R10 row closed at grant", {dram_ras_n, dram_cas_n}, 2'b11);
    repeat (10) @(negedge clk);
    ref_req = 1'b0;
    f0 = ras_falls;
    do_req(0, 16'h5678, 2'b00, 16'h0);
    drain();
    chk(ras_falls == f0 + 1, "R10 row reopened after refresh", ras_falls - f0, 1);

    // R8 long same-row stream forces a close
    do_req(1, 16'h9A00, 2'b11, 16'h1357);
    f0 = ras_falls;
    for (int i = 0; i < 70; i++) do_req(0, 16'h9A00 | 16'(i % 4), 2'b00, 16'h0);
    drain();
    chk(ras_falls >= f0 + 1, "R8 RAS closed during long page", ras_falls - f0, 1);

    // mixed traffic over a few rows
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(lf[0], {6'h0, lf[9:8], 4'h0, lf[3:0]}, lf[5:4], lf ^ 16'h5A5A);
    end
    drain();
    chk(accq.size() == 0, "R1 all accesses reached the pins", accq.size(), 0);
    chk(rexp.size() == 0, "R3 all reads returned", rexp.size(), 0);
    finish_run();
  end
endmodule